// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Takeover

This block is an eight-pin bidirectional I/O port that sits on a small memory-mapped register bus. Software owns two stored registers: a direction register, where a 1 makes a pin an input, and an output latch. A third address gives the synchronized levels seen on the pins. Each pin drives an external tri-state pad through a data line and an output-enable line, and reads it back through a data-in line.

Any pin can be handed to an on-chip peripheral. While a pin is handed over, the pad data comes from the peripheral. The peripheral can also take control of the pin direction and force the pin to drive or to float. That forced direction is never stored. Reading the direction register always returns what software last wrote, so software can safely read, modify and write that register while peripherals hold some of the pins. Reading the latch returns the stored latch value, not the pin level, so read-modify-write on the latch is also safe.

Top module: `gpio_port`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high at a clock edge, every direction bit becomes 1 (input), every latch bit becomes 0, and with no peripheral selected `pad_oe` is all zeros after that edge.
- R2: A write with `bus_addr` = 0 loads `bus_wdata` into the direction register at the clock edge. A read with `bus_addr` = 0 returns the direction register.
- R3: A write with `bus_addr` = 1 (latch) or `bus_addr` = 2 (port) loads `bus_wdata` into the output latch. A read with `bus_addr` = 1 returns the stored latch, even when the pin level differs.
- R4: A read with `bus_addr` = 2 returns the pad levels through a two-flop synchronizer. A change on `pad_in` that is present before edge k is first visible after edge k+1.
- R5: With `periph_sel[i]` = 0, `pad_out[i]` equals latch bit i and `pad_oe[i]` is the inverse of direction bit i.
- R6: With `periph_sel[i]` = 1, `pad_out[i]` equals `periph_dout[i]`.
- R7: With `periph_sel[i]` = 1 and `periph_dir_ovr[i]` = 1, `pad_oe[i]` equals `periph_oe[i]` whatever direction bit i holds. With `periph_sel[i]` = 0, `periph_dir_ovr` and `periph_oe` have no effect.
- R8: A direction override never alters the stored direction register. Readback at `bus_addr` = 0 is unchanged while an override is applied and after it is released.
- R9: `periph_din` carries the same synchronized pad levels that a read at `bus_addr` = 2 returns.
- R10: Address 3 is reserved. It reads as zero, and a write to it changes neither the direction register nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 port, 3 reserved |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Levels sensed on the pads |
| pad_out | output | 8 | Data driven toward the pads |
| pad_oe | output | 8 | Pad driver enable, 1 drives |
| periph_sel | input | 8 | Hands each pin to a peripheral |
| periph_dout | input | 8 | Peripheral output data |
| periph_dir_ovr | input | 8 | Peripheral takes direction control of the pin |
| periph_oe | input | 8 | Forced direction while overriding, 1 output and 0 input |
| periph_din | output | 8 | Synchronized pad levels for peripherals |

## Verification
The pad controls `pad_out` and `pad_oe` are combinational from the registers and the peripheral inputs. The bench therefore checks them in the low half of the same cycle in which the inputs change, or one edge after a register write. Read data for addresses 0 and 1 is due right after the write edge. Read data for address 2 and `periph_din` is due two edges after a pad change. The bench samples once after the first edge to confirm that the old value is still held, and again after the second edge to confirm the new one. All stimulus changes on falling edges and all sampling happens on falling edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int unsigned PORT_W      = 8;
    localparam int unsigned ADDR_W      = 2;
    localparam int unsigned SYNC_DEPTH  = 2;

    typedef enum logic [ADDR_W-1:0] {
        RSEL_DIR  = 2'd0,
        RSEL_LAT  = 2'd1,
        RSEL_PORT = 2'd2,
        RSEL_RSV  = 2'd3
    } reg_sel_e;

    // Per-pin control seen by the pad mux
    typedef struct packed {
        logic dir_in;    // stored direction, 1 = input
        logic lat;       // stored latch bit
        logic sel;       // peripheral owns the pin
        logic ovr;       // peripheral owns the direction
        logic p_oe;      // peripheral forced direction, 1 = drive
        logic p_dout;    // peripheral data
    } pin_ctl_t;

    typedef struct packed {
        logic out;
        logic oe;
    } pin_drv_t;

    function automatic pin_drv_t resolve_pin(input pin_ctl_t c);
        pin_drv_t d;
        d.out = c.sel ? c.p_dout : c.lat;
        if (c.sel && c.ovr) d.oe = c.p_oe;
        else                d.oe = ~c.dir_in;
        return d;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_sel_e          sel,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      lat_q
);

    logic dir_hit;
    logic lat_hit;

    assign dir_hit = wr && (sel == RSEL_DIR);
    assign lat_hit = wr && ((sel == RSEL_LAT) || (sel == RSEL_PORT));

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            lat_q <= '0;
        end else begin
            if (dir_hit) dir_q <= wdata;
            if (lat_hit) lat_q <= wdata;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (dir_q == '1 && lat_q == '0));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == RSEL_DIR) |=> dir_q == $past(wdata));

    assert_lat_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && (sel == RSEL_LAT || sel == RSEL_PORT)) |=> lat_q == $past(wdata));

    assert_rsv_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == RSEL_RSV) |=> ($stable(dir_q) && $stable(lat_q)));

    assert_dir_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(wr && sel == RSEL_DIR) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
#(
    parameter int unsigned W      = PORT_W,
    parameter int unsigned STAGES = SYNC_DEPTH
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end

        assert_chain_R4: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> stg[s] == $past(stg[s-1]));
    end

    assign q = stg[STAGES-1];

    assert_first_stage_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> stg[0] == $past(d));

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] lat_q,
    input  logic [W-1:0] p_sel,
    input  logic [W-1:0] p_ovr,
    input  logic [W-1:0] p_oe,
    input  logic [W-1:0] p_dout,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_ctl_t ctl;
        pin_drv_t drv;

        always_comb begin
            ctl.dir_in = dir_q[i];
            ctl.lat    = lat_q[i];
            ctl.sel    = p_sel[i];
            ctl.ovr    = p_ovr[i];
            ctl.p_oe   = p_oe[i];
            ctl.p_dout = p_dout[i];
            drv        = resolve_pin(ctl);
        end

        assign pad_out[i] = drv.out;
        assign pad_oe[i]  = drv.oe;

        assert_port_drive_R5: assert property (@(posedge clk) disable iff (rst)
            (!p_sel[i] && !dir_q[i]) |-> (pad_oe[i] && pad_out[i] == lat_q[i]));

        assert_port_hiz_R5: assert property (@(posedge clk) disable iff (rst)
            (!p_sel[i] && dir_q[i]) |-> !pad_oe[i]);

        assert_periph_data_R6: assert property (@(posedge clk) disable iff (rst)
            p_sel[i] |-> pad_out[i] == p_dout[i]);

        assert_force_dir_R7: assert property (@(posedge clk) disable iff (rst)
            (p_sel[i] && p_ovr[i]) |-> pad_oe[i] == p_oe[i]);
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned W = PORT_W
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    input  logic [W-1:0]      periph_sel,
    input  logic [W-1:0]      periph_dout,
    input  logic [W-1:0]      periph_dir_ovr,
    input  logic [W-1:0]      periph_oe,
    output logic [W-1:0]      periph_din
);

    reg_sel_e     sel;
    logic [W-1:0] dir_q;
    logic [W-1:0] lat_q;
    logic [W-1:0] pin_sync;

    assign sel = reg_sel_e'(bus_addr);

    gpio_regs #(.W(W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .dir_q (dir_q),
        .lat_q (lat_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    gpio_pinmux #(.W(W)) u_mux (
        .clk     (clk),
        .rst     (rst),
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .p_sel   (periph_sel),
        .p_ovr   (periph_dir_ovr),
        .p_oe    (periph_oe),
        .p_dout  (periph_dout),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    always_comb begin
        unique case (sel)
            RSEL_DIR:  bus_rdata = dir_q;
            RSEL_LAT:  bus_rdata = lat_q;
            RSEL_PORT: bus_rdata = pin_sync;
            default:   bus_rdata = '0;
        endcase
    end

    assign periph_din = pin_sync;

    assert_din_matches_port_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd2) |-> bus_rdata == periph_din);

    assert_rsv_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3) |-> bus_rdata == '0);

endmodule

// File: tb/gpio_port_bench.sv
module gpio_port_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] pad_in;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;
    logic [W-1:0] periph_sel = '0;
    logic [W-1:0] periph_dout = '0;
    logic [W-1:0] periph_dir_ovr = '0;
    logic [W-1:0] periph_oe = '0;
    logic [W-1:0] periph_din;

    // External pad model: chip driver wins, then an external driver, then the pull
    logic [W-1:0] ext_en = '0;
    logic [W-1:0] ext_val = '0;
    logic [W-1:0] pull_val = 8'hFF;

    always_comb begin
        for (int i = 0; i < W; i++)
            pad_in[i] = pad_oe[i] ? pad_out[i] : (ext_en[i] ? ext_val[i] : pull_val[i]);
    end

    always #5 clk = ~clk;

    gpio_port #(.W(W)) u_gpio_port (
        .clk            (clk),
        .rst            (rst),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .pad_in         (pad_in),
        .pad_out        (pad_out),
        .pad_oe         (pad_oe),
        .periph_sel     (periph_sel),
        .periph_dout    (periph_dout),
        .periph_dir_ovr (periph_dir_ovr),
        .periph_oe      (periph_oe),
        .periph_din     (periph_din)
    );

    int n_run  = 0;
    int n_fail = 0;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Pad-drive model taken from the requirement text
    function automatic logic [W-1:0] exp_out(input logic [W-1:0] lat, input logic [W-1:0] sel,
                                              input logic [W-1:0] pd);
        return (sel & pd) | (~sel & lat);
    endfunction

    function automatic logic [W-1:0] exp_oe(input logic [W-1:0] dir, input logic [W-1:0] sel,
                                             input logic [W-1:0] ovr, input logic [W-1:0] poe);
        logic [W-1:0] force_mask;
        force_mask = sel & ovr;
        return (force_mask & poe) | (~force_mask & ~dir);
    endfunction

    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] lat;
        logic [W-1:0] sel;
        logic [W-1:0] ovr;
        logic [W-1:0] poe;
        logic [W-1:0] pd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{dir: 8'hCF, lat: 8'h30, sel: 8'h00, ovr: 8'h00, poe: 8'h00, pd: 8'h00},
        '{dir: 8'h00, lat: 8'hA5, sel: 8'h00, ovr: 8'hFF, poe: 8'h00, pd: 8'hFF},
        '{dir: 8'hFF, lat: 8'h5A, sel: 8'h00, ovr: 8'hFF, poe: 8'hFF, pd: 8'hFF},
        '{dir: 8'h00, lat: 8'h00, sel: 8'hFF, ovr: 8'h00, poe: 8'h00, pd: 8'h96},
        '{dir: 8'hFF, lat: 8'hFF, sel: 8'h0F, ovr: 8'h0F, poe: 8'h0F, pd: 8'h03},
        '{dir: 8'h00, lat: 8'hF0, sel: 8'hF0, ovr: 8'hF0, poe: 8'h00, pd: 8'hAA},
        '{dir: 8'h55, lat: 8'h33, sel: 8'h3C, ovr: 8'h18, poe: 8'h08, pd: 8'h24},
        '{dir: 8'hA0, lat: 8'h0F, sel: 8'hC3, ovr: 8'h81, poe: 8'h01, pd: 8'h42}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] rd;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        bus_read(2'd0, rd); check("R1 dir reset", rd, 8'hFF);
        bus_read(2'd1, rd); check("R1 latch reset", rd, 8'h00);
        check("R1 oe reset", pad_oe, 8'h00);

        // Table walk: R2, R5, R6, R7, R8
        for (int v = 0; v < NV; v++) begin
            bus_write(2'd0, VECS[v].dir);
            bus_write(2'd1, VECS[v].lat);
            periph_sel     = VECS[v].sel;
            periph_dir_ovr = VECS[v].ovr;
            periph_oe      = VECS[v].poe;
            periph_dout    = VECS[v].pd;
            #1;
            check("R5/R6 pad_out", pad_out, exp_out(VECS[v].lat, VECS[v].sel, VECS[v].pd));
            check("R5/R7 pad_oe", pad_oe, exp_oe(VECS[v].dir, VECS[v].sel, VECS[v].ovr, VECS[v].poe));
            bus_read(2'd0, rd); check("R2/R8 dir readback under override", rd, VECS[v].dir);
            bus_read(2'd1, rd); check("R3 latch readback", rd, VECS[v].lat);
            @(negedge clk);
        end

        // R8: release overrides, direction still what software wrote
        periph_sel = '0; periph_dir_ovr = '0; periph_oe = '0; periph_dout = '0;
        #1;
        bus_read(2'd0, rd); check("R8 dir after release", rd, VECS[NV-1].dir);
        check("R8 oe after release", pad_oe, ~VECS[NV-1].dir);

        // R7: override inputs ignored while pin is not selected
        bus_write(2'd0, 8'h0F);
        bus_write(2'd1, 8'h99);
        periph_dir_ovr = 8'hFF; periph_oe = 8'hF0; periph_dout = 8'h66;
        #1;
        check("R7 unselected oe", pad_oe, 8'hF0);
        check("R7 unselected out", pad_out, 8'h99);
        periph_dir_ovr = '0; periph_oe = '0; periph_dout = '0;

        // R3: latch read differs from pin level
        bus_write(2'd0, 8'hFF);
        bus_write(2'd1, 8'hA5);
        ext_en = 8'hFF; ext_val = 8'h3C;
        repeat (3) @(negedge clk);
        bus_read(2'd1, rd); check("R3 latch not pin", rd, 8'hA5);
        bus_read(2'd2, rd); check("R4 port level", rd, 8'h3C);
        check("R9 periph_din", periph_din, 8'h3C);

        // R3: write via port address lands in latch
        bus_write(2'd2, 8'h5A);
        bus_read(2'd1, rd); check("R3 port write to latch", rd, 8'h5A);

        // R4: two-edge synchronizer latency
        @(negedge clk);
        ext_val = 8'hC3;
        @(negedge clk);
        bus_read(2'd2, rd); check("R4 old value after one edge", rd, 8'h3C);
        @(negedge clk);
        bus_read(2'd2, rd); check("R4 new value after two edges", rd, 8'hC3);
        check("R9 periph_din follows", periph_din, 8'hC3);

        // R4: pin driven by the port itself reads back through the pad
        ext_en = '0;
        bus_write(2'd0, 8'h00);
        bus_write(2'd1, 8'h81);
        repeat (2) @(negedge clk);
        bus_read(2'd2, rd); check("R4 driven loopback", rd, 8'h81);

        // R10: reserved address
        bus_write(2'd3, 8'h77);
        bus_read(2'd0, rd); check("R10 dir untouched", rd, 8'h00);
        bus_read(2'd1, rd); check("R10 latch untouched", rd, 8'h81);
        bus_read(2'd3, rd); check("R10 reads zero", rd, 8'h00);

        // R1: reset mid-run restores defaults
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_read(2'd0, rd); check("R1 dir after reset", rd, 8'hFF);
        bus_read(2'd1, rd); check("R1 latch after reset", rd, 8'h00);
        check("R1 oe after reset", pad_oe, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule